// File: doc/BRIEF.md
# Address-Specifier Byte Parser

This block walks the operand-addressing bytes of a variable-length 32-bit CISC instruction. It starts on the byte that follows the opcode. The caller pulses `start` and supplies three values: the operand-size bit, the size of the immediate, and the number of bytes already consumed by prefixes and opcode. The parser then accepts one byte per cycle over a valid/ready handshake.

The first byte is the specifier. Its fields decide what comes next:
- an optional scaled-index byte,
- a displacement of zero, one or four bytes,
- the immediate, if the caller asked for one.

Once the last byte is in, the parser reads two register values through a combinational register-file port and adds up the effective address. It then emits a one-cycle completion pulse. The pulse carries either the address or a register-operand indication, together with the decoded register codes, the immediate and the total instruction length. The length is flagged as an error when it exceeds 17 bytes.

A decode pipeline uses it as the front half of operand fetch. Prefix and opcode handling, 16-bit addressing, segmentation and the memory access itself are done elsewhere.

Top module: `addr_spec_parser`

## Requirements
- R1: The specifier byte is read as md=[7:6], rg=[5:3], rm=[2:0]. `reg_code` reports {~op_wide, rg}, so bit 3 set means a byte-size register.
- R2: With md=0 and rm neither 4 nor 5, no displacement byte is taken and `ea` equals the register-file value of register rm.
- R3: md=1 takes one displacement byte, sign-extended to 32 bits. md=2 takes four bytes, least-significant first. The sum wraps modulo 2^32. With md 1 or 2 and rm=5, register 5 is the base.
- R4: md=3 takes no scaled-index byte and no displacement. At completion `is_reg_op`=1, `ea`=0 and `rm_code`={~op_wide, rm}.
- R5: md=0 with rm=5 takes a four-byte displacement, and `ea` equals it with no base register added.
- R6: When md is not 3 and rm=4, a scaled-index byte follows: scale=[7:6], index=[5:3], base=[2:0]. `ea` = base + (index << scale) + displacement. Index code 4 adds no index. Base code 5 with md=0 adds no base and takes a four-byte displacement.
- R7: `op_wide`, `imm_sel` and `pre_len` are captured at the accepted `start`. A `start` that arrives while a parse is in progress is ignored.
- R8: The immediate follows any displacement. `imm_sel`=0 means none, 1 means one byte zero-extended, and 2 or 3 means four bytes least-significant first. The result is on `imm_val`.
- R9: `byte_count` = `pre_len` + the number of bytes accepted. `len_err` is 1 exactly when `byte_count` exceeds 17.
- R10: A byte is taken only on a cycle with `in_valid` and `in_ready` both high. `in_ready` is high only while a byte is expected. `done` is a single-cycle pulse, and `in_ready` is low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a parse (accepted only when idle) |
| op_wide | input | 1 | Operand size: 1 double word, 0 byte |
| imm_sel | input | 2 | Immediate size: 0 none, 1 one byte, 2/3 four bytes |
| pre_len | input | 4 | Bytes consumed before the specifier byte |
| in_valid | input | 1 | Instruction byte available |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Parser takes a byte this cycle |
| rf_base_sel | output | 3 | Register-file read address for the base |
| rf_base_val | input | 32 | Base register value |
| rf_index_sel | output | 3 | Register-file read address for the index |
| rf_index_val | input | 32 | Index register value |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 32 | Effective address (0 for a register operand) |
| is_reg_op | output | 1 | Operand is a register, no address formed |
| reg_code | output | 4 | {~op_wide, rg} |
| rm_code | output | 4 | {~op_wide, rm} |
| imm_val | output | 32 | Immediate value |
| byte_count | output | 5 | Total instruction length |
| len_err | output | 1 | Length exceeds 17 bytes |

## Verification
The hardest cases to reach from the ports are the combinations where one field overrides the meaning of another:
- a scaled-index base code 5 under md=0 removes the base and lengthens the displacement;
- index code 4 removes the index;
- rm=5 under md=1 selects a real base while under md=0 it selects none.

The stimulus feeds each of these combinations as an explicit byte sequence against a register file whose entries all differ. A wrong base or index therefore shows up in the address. The length limit is hit with the longest sequence (scaled-index byte, four-byte displacement and four-byte immediate), once at exactly 17 bytes and once at 18. A gapped `in_valid` stream and a stray `start` injected mid-parse check the handshake and the capture of the per-instruction inputs.

// File: rtl/addr_spec_pkg.sv
package addr_spec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPEC,
    ST_SIB,
    ST_DISP,
    ST_IMM,
    ST_CALC
  } parse_st_t;

  // decoded view of the specifier byte
  typedef struct packed {
    logic       reg_op;
    logic       has_sib;
    logic       base_en;
    logic [2:0] disp_len;
  } spec_info_t;

  // decoded view of the scaled-index byte
  typedef struct packed {
    logic       base_en;
    logic       index_en;
    logic       disp_force32;
  } sib_info_t;

  function automatic logic [31:0] sext8(input logic [7:0] b);
    return {{24{b[7]}}, b};
  endfunction

  function automatic logic [31:0] scaled(input logic [31:0] v, input logic [1:0] sc);
    return v << sc;
  endfunction

  function automatic logic [31:0] disp_value(input logic [31:0] raw, input logic [2:0] len);
    return (len == 3'd1) ? sext8(raw[7:0]) : raw;
  endfunction

  function automatic logic [2:0] imm_bytes(input logic [1:0] sel, input int nb);
    if (sel[1]) return 3'(nb);
    if (sel[0]) return 3'd1;
    return 3'd0;
  endfunction

endpackage

// File: rtl/as_spec_dec.sv
module as_spec_dec
  import addr_spec_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic [7:0] spec,
  output spec_info_t info
);
  logic [1:0] md;
  logic [2:0] rm;

  always_comb begin
    md = spec[7:6];
    rm = spec[2:0];
    info.reg_op  = (md == 2'd3);
    info.has_sib = (md != 2'd3) && (rm == 3'd4);
    info.base_en = !((md == 2'd0) && (rm == 3'd5));
    unique case (md)
      2'd0:    info.disp_len = (rm == 3'd5) ? 3'(NB) : 3'd0;
      2'd1:    info.disp_len = 3'd1;
      2'd2:    info.disp_len = 3'(NB);
      default: info.disp_len = 3'd0;
    endcase
  end
endmodule

// File: rtl/as_sib_dec.sv
module as_sib_dec
  import addr_spec_pkg::*;
(
  input  logic [7:0] sib,
  input  logic [1:0] md,
  output sib_info_t  info
);
  always_comb begin
    info.index_en     = (sib[5:3] != 3'd4);
    info.disp_force32 = (md == 2'd0) && (sib[2:0] == 3'd5);
    info.base_en      = !info.disp_force32;
  end
endmodule

// File: rtl/as_ea_unit.sv
module as_ea_unit
  import addr_spec_pkg::*;
(
  input  logic        reg_op,
  input  logic        base_en,
  input  logic [31:0] base_val,
  input  logic        index_en,
  input  logic [31:0] index_val,
  input  logic [1:0]  scale,
  input  logic [31:0] disp_raw,
  input  logic [2:0]  disp_len,
  output logic [31:0] ea
);
  logic [31:0] b_term, i_term, d_term;

  always_comb begin
    b_term = base_en  ? base_val : 32'd0;
    i_term = index_en ? scaled(index_val, scale) : 32'd0;
    d_term = disp_value(disp_raw, disp_len);
    ea     = reg_op ? 32'd0 : (b_term + i_term + d_term);
  end
endmodule

// File: rtl/addr_spec_parser.sv
module addr_spec_parser
  import addr_spec_pkg::*;
#(
  parameter int MAX_LEN = 17,
  parameter int PRE_W   = 4,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_wide,
  input  logic [1:0]        imm_sel,
  input  logic [PRE_W-1:0]  pre_len,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic [2:0]        rf_base_sel,
  input  logic [ADDR_W-1:0] rf_base_val,
  output logic [2:0]        rf_index_sel,
  input  logic [ADDR_W-1:0] rf_index_val,
  output logic              done,
  output logic [ADDR_W-1:0] ea,
  output logic              is_reg_op,
  output logic [3:0]        reg_code,
  output logic [3:0]        rm_code,
  output logic [ADDR_W-1:0] imm_val,
  output logic [4:0]        byte_count,
  output logic              len_err
);
  localparam int NB      = ADDR_W / 8;
  localparam int MAX_TOT = (1 << PRE_W) + 1 + 2 * NB;
  localparam int CNT_W   = $clog2(MAX_TOT + 1);

  parse_st_t         st;
  logic              w_q;
  logic [2:0]        imm_len_q, disp_len_q, idx_q;
  logic [PRE_W-1:0]  pre_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        spec_q, sib_q;
  logic              has_sib_q, reg_op_q, base_en_q, index_en_q;
  logic [ADDR_W-1:0] disp_q, imm_q;

  spec_info_t spec_i;
  sib_info_t  sib_i;
  logic [ADDR_W-1:0] ea_calc;
  logic [CNT_W-1:0]  total;

  // named events for the checker
  logic accept, sib_taken, in_calc;

  assign in_ready  = (st == ST_SPEC) || (st == ST_SIB) || (st == ST_DISP) || (st == ST_IMM);
  assign accept    = in_valid && in_ready;
  assign sib_taken = accept && (st == ST_SIB);
  assign in_calc   = (st == ST_CALC);
  assign total     = CNT_W'(pre_q) + cnt_q;

  as_spec_dec #(.NB(NB)) u_spec (.spec(in_byte), .info(spec_i));
  as_sib_dec u_sib (.sib(in_byte), .md(spec_q[7:6]), .info(sib_i));

  assign rf_base_sel  = has_sib_q ? sib_q[2:0] : spec_q[2:0];
  assign rf_index_sel = sib_q[5:3];

  as_ea_unit u_ea (
    .reg_op   (reg_op_q),
    .base_en  (base_en_q),
    .base_val (rf_base_val),
    .index_en (index_en_q),
    .index_val(rf_index_val),
    .scale    (sib_q[7:6]),
    .disp_raw (disp_q),
    .disp_len (disp_len_q),
    .ea       (ea_calc)
  );

  function automatic parse_st_t after_addr(input logic [2:0] dl, input logic [2:0] il);
    if (dl != 3'd0) return ST_DISP;
    if (il != 3'd0) return ST_IMM;
    return ST_CALC;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      w_q        <= 1'b0;
      imm_len_q  <= '0;
      disp_len_q <= '0;
      idx_q      <= '0;
      pre_q      <= '0;
      cnt_q      <= '0;
      spec_q     <= '0;
      sib_q      <= '0;
      has_sib_q  <= 1'b0;
      reg_op_q   <= 1'b0;
      base_en_q  <= 1'b0;
      index_en_q <= 1'b0;
      disp_q     <= '0;
      imm_q      <= '0;
      done       <= 1'b0;
      ea         <= '0;
      is_reg_op  <= 1'b0;
      reg_code   <= '0;
      rm_code    <= '0;
      imm_val    <= '0;
      byte_count <= '0;
      len_err    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) cnt_q <= cnt_q + 1'b1;
      unique case (st)
        ST_IDLE: if (start) begin
          w_q        <= op_wide;
          imm_len_q  <= imm_bytes(imm_sel, NB);
          pre_q      <= pre_len;
          cnt_q      <= '0;
          idx_q      <= '0;
          disp_q     <= '0;
          imm_q      <= '0;
          sib_q      <= '0;
          has_sib_q  <= 1'b0;
          index_en_q <= 1'b0;
          st         <= ST_SPEC;
        end
        ST_SPEC: if (accept) begin
          spec_q     <= in_byte;
          reg_op_q   <= spec_i.reg_op;
          has_sib_q  <= spec_i.has_sib;
          base_en_q  <= spec_i.base_en;
          disp_len_q <= spec_i.disp_len;
          if (spec_i.has_sib) st <= ST_SIB;
          else                st <= after_addr(spec_i.disp_len, imm_len_q);
        end
        ST_SIB: if (accept) begin
          sib_q      <= in_byte;
          index_en_q <= sib_i.index_en;
          base_en_q  <= sib_i.base_en;
          if (sib_i.disp_force32) begin
            disp_len_q <= 3'(NB);
            st         <= ST_DISP;
          end else begin
            st <= after_addr(disp_len_q, imm_len_q);
          end
        end
        ST_DISP: if (accept) begin
          disp_q[{idx_q, 3'b000} +: 8] <= in_byte;
          if (idx_q == disp_len_q - 3'd1) begin
            idx_q <= '0;
            st    <= (imm_len_q != 3'd0) ? ST_IMM : ST_CALC;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        ST_IMM: if (accept) begin
          imm_q[{idx_q, 3'b000} +: 8] <= in_byte;
          if (idx_q == imm_len_q - 3'd1) begin
            idx_q <= '0;
            st    <= ST_CALC;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end
        ST_CALC: begin
          done       <= 1'b1;
          ea         <= ea_calc;
          is_reg_op  <= reg_op_q;
          reg_code   <= {~w_q, spec_q[5:3]};
          rm_code    <= {~w_q, spec_q[2:0]};
          imm_val    <= imm_q;
          byte_count <= 5'(total);
          len_err    <= (total > CNT_W'(MAX_LEN));
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/as_parser_chk.sv
module as_parser_chk #(
  parameter int MAX_LEN = 17
) (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        in_ready,
  input logic        is_reg_op,
  input logic [31:0] ea,
  input logic [4:0]  byte_count,
  input logic        len_err,
  input logic        sib_taken,
  input logic [7:0]  spec_q,
  input logic        in_calc
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R10
  no_ready_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !in_ready);

  // R10
  done_after_calc_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(in_calc));

  // R4
  reg_op_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && is_reg_op) |-> (ea == 32'd0));

  // R6
  sib_only_when_coded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sib_taken |-> (spec_q[2:0] == 3'd4 && spec_q[7:6] != 2'd3));

  // R9
  len_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (len_err == (byte_count > 5'(MAX_LEN))));
endmodule

bind addr_spec_parser as_parser_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .in_ready  (in_ready),
  .is_reg_op (is_reg_op),
  .ea        (ea),
  .byte_count(byte_count),
  .len_err   (len_err),
  .sib_taken (sib_taken),
  .spec_q    (spec_q),
  .in_calc   (in_calc)
);

// File: tb/addr_spec_parser_bench.sv
module addr_spec_parser_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_wide = 1'b1;
  logic [1:0]  imm_sel = 2'd0;
  logic [3:0]  pre_len = 4'd1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'd0;
  logic        in_ready;
  logic [2:0]  rf_base_sel, rf_index_sel;
  logic [31:0] rf_base_val, rf_index_val;
  logic        done;
  logic [31:0] ea, imm_val;
  logic        is_reg_op, len_err;
  logic [3:0]  reg_code, rm_code;
  logic [4:0]  byte_count;

  int total = 0;
  int bad = 0;
  logic [7:0] seq [16];
  logic got;

  always #4 clk = ~clk;

  function automatic logic [31:0] rfv(input logic [2:0] s);
    return 32'hF000_0000 + ({29'd0, s} * 32'h0101_0101);
  endfunction

  assign rf_base_val  = rfv(rf_base_sel);
  assign rf_index_val = rfv(rf_index_sel);

  addr_spec_parser u_addr_spec_parser (
    .clk(clk), .rst_n(rst_n), .start(start), .op_wide(op_wide), .imm_sel(imm_sel),
    .pre_len(pre_len), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .rf_base_sel(rf_base_sel), .rf_base_val(rf_base_val),
    .rf_index_sel(rf_index_sel), .rf_index_val(rf_index_val),
    .done(done), .ea(ea), .is_reg_op(is_reg_op), .reg_code(reg_code), .rm_code(rm_code),
    .imm_val(imm_val), .byte_count(byte_count), .len_err(len_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input int gap);
    for (int g = 0; g < gap; g++) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // feed n bytes of seq, wait for completion, check the pulse width
  task automatic run(input logic w, input logic [1:0] isel, input logic [3:0] pl,
                     input int n, input int gap, input logic poke);
    @(negedge clk);
    op_wide = w; imm_sel = isel; pre_len = pl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      push(seq[i], gap);
      if (poke && i == 0) begin
        @(negedge clk);
        start = 1'b1; op_wide = ~w; imm_sel = 2'd0; pre_len = 4'd0;
        @(negedge clk);
        start = 1'b0;
      end
    end
    got = 1'b0;
    for (int k = 0; k < 8 && !got; k++) begin
      @(negedge clk);
      if (done) got = 1'b1;
    end
    chk("R10 done seen", {31'd0, got}, 32'd1);
    if (got) begin
      chk("R10 ready low at done", {31'd0, in_ready}, 32'd0);
      @(negedge clk);
      chk("R10 done one cycle", {31'd0, done}, 32'd0);
    end
  endtask

  task automatic t_reset;
    chk("R10 reset done", {31'd0, done}, 32'd0);
    chk("R10 reset ready", {31'd0, in_ready}, 32'd0);
  endtask

  task automatic t_mod0;
    seq[0] = 8'h03;
    run(1'b1, 2'd0, 4'd1, 1, 0, 1'b0);
    chk("R2 ea", ea, rfv(3'd3));
    chk("R1 reg_code", {28'd0, reg_code}, 32'h0);
    chk("R9 count", {27'd0, byte_count}, 32'd2);
    chk("R4 not reg", {31'd0, is_reg_op}, 32'd0);
  endtask

  task automatic t_mod1_neg;
    seq[0] = 8'h4D; seq[1] = 8'hF0;
    run(1'b1, 2'd0, 4'd1, 2, 0, 1'b0);
    chk("R3 disp8 neg", ea, rfv(3'd5) - 32'd16);
    chk("R1 reg_code", {28'd0, reg_code}, 32'h1);
    chk("R9 count", {27'd0, byte_count}, 32'd3);
  endtask

  task automatic t_mod2_wrap;
    seq[0] = 8'h87; seq[1] = 8'h00; seq[2] = 8'h00; seq[3] = 8'h00; seq[4] = 8'h20;
    run(1'b1, 2'd0, 4'd1, 5, 0, 1'b0);
    chk("R3 disp32 wrap", ea, rfv(3'd7) + 32'h2000_0000);
    chk("R9 count", {27'd0, byte_count}, 32'd6);
  endtask

  task automatic t_mod3;
    seq[0] = 8'hD6; seq[1] = 8'h9C;
    run(1'b0, 2'd1, 4'd2, 2, 0, 1'b0);
    chk("R4 is_reg", {31'd0, is_reg_op}, 32'd1);
    chk("R4 ea zero", ea, 32'd0);
    chk("R4 rm_code", {28'd0, rm_code}, 32'hE);
    chk("R7 reg_code byte", {28'd0, reg_code}, 32'hA);
    chk("R8 imm8", imm_val, 32'h9C);
    chk("R9 count", {27'd0, byte_count}, 32'd4);
  endtask

  task automatic t_abs;
    seq[0] = 8'h1D; seq[1] = 8'h78; seq[2] = 8'h56; seq[3] = 8'h34; seq[4] = 8'h12;
    run(1'b1, 2'd0, 4'd1, 5, 0, 1'b0);
    chk("R5 disp only", ea, 32'h1234_5678);
    chk("R1 reg_code", {28'd0, reg_code}, 32'h3);
  endtask

  task automatic t_sib_full;
    seq[0] = 8'h44; seq[1] = 8'hCA; seq[2] = 8'h04;
    run(1'b1, 2'd0, 4'd1, 3, 0, 1'b0);
    chk("R6 base+idx*8+d", ea, rfv(3'd2) + (rfv(3'd1) << 3) + 32'd4);
    chk("R9 count", {27'd0, byte_count}, 32'd4);
  endtask

  task automatic t_sib_none;
    seq[0] = 8'h04; seq[1] = 8'hA5;
    seq[2] = 8'hEF; seq[3] = 8'hBE; seq[4] = 8'hAD; seq[5] = 8'hDE;
    run(1'b1, 2'd0, 4'd1, 6, 0, 1'b0);
    chk("R6 no base no idx", ea, 32'hDEAD_BEEF);
  endtask

  task automatic t_sib_idx_only;
    seq[0] = 8'h04; seq[1] = 8'h75;
    seq[2] = 8'h10; seq[3] = 8'h00; seq[4] = 8'h00; seq[5] = 8'h00;
    run(1'b1, 2'd0, 4'd1, 6, 0, 1'b0);
    chk("R6 idx*2 + d32", ea, (rfv(3'd6) << 1) + 32'h10);
  endtask

  task automatic t_sib_base5_md1;
    seq[0] = 8'h44; seq[1] = 8'h25; seq[2] = 8'hFF;
    run(1'b1, 2'd0, 4'd1, 3, 0, 1'b0);
    chk("R6 base5 under md1", ea, rfv(3'd5) - 32'd1);
    chk("R9 count", {27'd0, byte_count}, 32'd4);
  endtask

  task automatic t_imm32_gaps;
    seq[0] = 8'hC1; seq[1] = 8'h11; seq[2] = 8'h22; seq[3] = 8'h33; seq[4] = 8'h44;
    run(1'b1, 2'd2, 4'd1, 5, 2, 1'b0);
    chk("R8 imm32", imm_val, 32'h4433_2211);
    chk("R10 gapped count", {27'd0, byte_count}, 32'd6);
    chk("R4 is_reg", {31'd0, is_reg_op}, 32'd1);
  endtask

  task automatic t_len(input logic [3:0] pl, input logic exp_err);
    seq[0] = 8'h84; seq[1] = 8'h00;
    seq[2] = 8'h01; seq[3] = 8'h00; seq[4] = 8'h00; seq[5] = 8'h00;
    seq[6] = 8'hAA; seq[7] = 8'hBB; seq[8] = 8'hCC; seq[9] = 8'hDD;
    run(1'b1, 2'd3, pl, 10, 0, 1'b0);
    chk("R9 long count", {27'd0, byte_count}, 32'(pl) + 32'd10);
    chk("R9 len_err", {31'd0, len_err}, {31'd0, exp_err});
    chk("R8 imm after disp", imm_val, 32'hDDCC_BBAA);
    chk("R6 idx scale1", ea, rfv(3'd0) + rfv(3'd0) + 32'd1);
  endtask

  task automatic t_busy_start;
    seq[0] = 8'h4D; seq[1] = 8'h08;
    run(1'b1, 2'd0, 4'd1, 2, 0, 1'b1);
    chk("R7 w kept", {28'd0, reg_code}, 32'h1);
    chk("R7 pre kept", {27'd0, byte_count}, 32'd3);
    chk("R7 addr", ea, rfv(3'd5) + 32'd8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_mod0();
    t_mod1_neg();
    t_mod2_wrap();
    t_mod3();
    t_abs();
    t_sib_full();
    t_sib_none();
    t_sib_idx_only();
    t_sib_base5_md1();
    t_imm32_gaps();
    t_len(4'd7, 1'b0);
    t_len(4'd8, 1'b1);
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule